// File: doc/BRIEF.md
# Text-Mode Glyph Fetch Engine

This block produces the memory traffic and pixel stream for a 320x200 text display made of 40 columns by 25 rows of 8x8 cells. It follows the raster position, which arrives on its inputs, and issues read requests on a single memory port. On the first raster line of each character row it pauses the processor. It then takes the processor's share of the memory slots to read that row's 40 character codes into an internal line buffer. On every visible line it combines the buffered code of each cell with the line number inside the row to form a glyph address. It reads the glyph byte and serializes it into a one-bit pixel stream.

Each 8-pixel cell period carries two memory slots. Offset 0 is the video slot, which is used for glyph reads. Offset 4 is the processor slot, which the block takes only on code-fetch lines. Fetches run two cells ahead of the display. As a result, the glyph of the first cell is ready before the first visible pixel, and every cell uses its own code.

Top module: `text_video_fetch`

## Requirements
- R1: During and right after reset, `pixOut`, `memReq` and `cpuStall` are 0. They stay 0 for a whole raster line outside the active band `ACT_Y0 <= rasterY < ACT_Y0+200`.
- R2: On a code-fetch line (active, `(rasterY-ACT_Y0) mod 8 == 0`), exactly 40 code reads occur. Read k is requested while `rasterX == ACT_X0-16+8k+4`, at address `SCREEN_BASE + row*40 + k`, where `row = (rasterY-ACT_Y0)/8`. No other line issues code reads.
- R3: `cpuStall` is 1 exactly for `ACT_X0-16-3 <= rasterX <= ACT_X0-16+8*39+5` on a code-fetch line, and 0 at all other times.
- R4: A glyph read uses the address `CHARSET_BASE + code*8 + lineInRow`, where `lineInRow = (rasterY-ACT_Y0) mod 8`.
- R5: Lines 1 to 7 of a row use the codes captured on the row's code-fetch line, even when screen memory changed after that line.
- R6: On every active line, the glyph read for cell c is requested while `rasterX == ACT_X0-16+8(c+1)`, for c = 0..39. `memReq` is 0 at every other position.
- R7: For `rasterX = ACT_X0+8c+i` (i = 0..7) on an active line, `pixOut` in the next cycle equals bit 7-i of cell c's glyph byte (MSB first, 1 = foreground).
- R8: The first cell shows its own glyph from its first pixel on a code-fetch line. The last cell is not repeated at the start of the row, and no cell repeats its neighbour.
- R9: `pixOut` is 0 in the cycle after any raster position outside the 320-pixel active window or outside the active band.
- R10: Read data on `memData` is taken in the cycle after the request (one-cycle read latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rasterX | input | 9 | Horizontal raster position, pixels |
| rasterY | input | 9 | Vertical raster position, lines |
| memReq | output | 1 | Read request, valid this cycle |
| memAddr | output | 16 | Read address |
| memData | input | 8 | Read data, one cycle after request |
| cpuStall | output | 1 | Processor pause during code fetch |
| pixOut | output | 1 | Serial pixel, 1 = foreground |

## Verification
Screen and glyph memory are filled from a seeded random source. The bench then drives whole raster lines: code-fetch lines of randomly chosen rows, followed by a non-fetch line of the same row after screen memory has been rewritten. A stale-buffer bug and a refetch bug produce different glyph addresses, so this pattern tells them apart. One directed row puts distinct codes in the first, second and last cells, which exposes duplication or wraparound at the row edges. The first and last rows and lines just outside the active band separate off-by-one errors in the row decode from errors in the stall window.

// File: rtl/tvf_pkg.sv
package tvf_pkg;
  // Control-to-datapath strobes, one set per pixel clock.
  typedef struct packed {
    logic       ptrReq;
    logic       ptrCapture;
    logic       glyphReq;
    logic       glyphCapture;
    logic       pixLoad;
    logic       pixActive;
    logic       stall;
    logic [7:0] cellIdx;
    logic [7:0] rowIdx;
    logic [2:0] lineInRow;
  } tvfStrobes_t;
endpackage

// File: rtl/tvf_ctrl.sv
module tvf_ctrl
  import tvf_pkg::*;
#(
  parameter int COLS       = 40,
  parameter int ROWS       = 25,
  parameter int XW         = 9,
  parameter int YW         = 9,
  parameter int ACT_X0     = 48,
  parameter int ACT_Y0     = 16,
  parameter int STALL_LEAD = 3
) (
  input  logic [XW-1:0] rasterX,
  input  logic [YW-1:0] rasterY,
  output tvfStrobes_t   strobes
);
  localparam int FETCH_X0  = ACT_X0 - 16;
  localparam int FETCH_END = FETCH_X0 + 8 * (COLS + 1);
  localparam int STALL_X0  = FETCH_X0 - STALL_LEAD;
  localparam int STALL_X1  = FETCH_X0 + 8 * (COLS - 1) + 5;
  localparam int ACT_X1    = ACT_X0 + 8 * COLS;
  localparam int ACT_Y1    = ACT_Y0 + 8 * ROWS;

  always_comb begin
    int x, y, rel, slot, off, ry, ax;
    logic activeLine, fetchLine, inFetch, inPix;
    x = int'(rasterX);
    y = int'(rasterY);
    activeLine = (y >= ACT_Y0) && (y < ACT_Y1);
    ry   = activeLine ? (y - ACT_Y0) : 0;
    fetchLine = activeLine && ((ry % 8) == 0);
    inFetch = (x >= FETCH_X0) && (x < FETCH_END);
    rel  = inFetch ? (x - FETCH_X0) : 0;
    slot = rel / 8;
    off  = rel % 8;
    inPix = activeLine && (x >= ACT_X0) && (x < ACT_X1);
    ax   = inPix ? (x - ACT_X0) : 0;

    strobes              = '0;
    strobes.lineInRow    = 3'(ry % 8);
    strobes.rowIdx       = 8'(ry / 8);
    strobes.ptrReq       = fetchLine && inFetch && (slot < COLS) && (off == 4);
    strobes.ptrCapture   = fetchLine && inFetch && (slot < COLS) && (off == 5);
    strobes.glyphReq     = activeLine && inFetch && (slot >= 1) && (off == 0);
    strobes.glyphCapture = activeLine && inFetch && (slot >= 1) && (off == 1);
    // Code slots address cell 'slot'; glyph slots address the cell before.
    strobes.cellIdx      = (off >= 4) ? 8'(slot) : 8'((slot > 0) ? slot - 1 : 0);
    strobes.pixActive    = inPix;
    strobes.pixLoad      = inPix && ((ax % 8) == 0);
    strobes.stall        = fetchLine && (x >= STALL_X0) && (x <= STALL_X1);
  end
endmodule

// File: rtl/tvf_datapath.sv
module tvf_datapath
  import tvf_pkg::*;
#(
  parameter int          COLS         = 40,
  parameter int          AW           = 16,
  parameter logic [15:0] SCREEN_BASE  = 16'h0400,
  parameter logic [15:0] CHARSET_BASE = 16'h1000
) (
  input  logic          clk,
  input  logic          rstN,
  input  tvfStrobes_t   strobes,
  input  logic [7:0]    memData,
  output logic          memReq,
  output logic [AW-1:0] memAddr,
  output logic          cpuStall,
  output logic          pixOut
);
  localparam int CW = $clog2(COLS);

  logic [7:0] codeBuf [COLS];
  logic [7:0] curCode;
  logic [7:0] glyphHold;
  logic [6:0] shiftReg;
  logic       pixReg;

  // Line buffer: write index is the code slot, so it restarts at 0 every fetch line.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < COLS; i++) codeBuf[i] <= '0;
    end else if (strobes.ptrCapture && (strobes.cellIdx < 8'(COLS))) begin
      codeBuf[strobes.cellIdx[CW-1:0]] <= memData;
    end
  end

  assign curCode = (strobes.cellIdx < 8'(COLS)) ? codeBuf[strobes.cellIdx[CW-1:0]] : 8'h00;

  always_comb begin
    if (strobes.ptrReq)
      memAddr = AW'(SCREEN_BASE) + AW'(strobes.rowIdx) * AW'(COLS) + AW'(strobes.cellIdx);
    else
      memAddr = AW'(CHARSET_BASE) + {{(AW-11){1'b0}}, curCode, 3'b000} + AW'(strobes.lineInRow);
  end

  assign memReq   = strobes.ptrReq | strobes.glyphReq;
  assign cpuStall = strobes.stall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      glyphHold <= '0;
      shiftReg  <= '0;
      pixReg    <= 1'b0;
    end else begin
      if (strobes.glyphCapture) glyphHold <= memData;
      if (strobes.pixLoad) begin
        pixReg   <= glyphHold[7];
        shiftReg <= glyphHold[6:0];
      end else if (strobes.pixActive) begin
        pixReg   <= shiftReg[6];
        shiftReg <= {shiftReg[5:0], 1'b0};
      end else begin
        pixReg <= 1'b0;
      end
    end
  end

  assign pixOut = pixReg;
endmodule

// File: rtl/text_video_fetch.sv
module text_video_fetch
  import tvf_pkg::*;
#(
  parameter int          COLS         = 40,
  parameter int          ROWS         = 25,
  parameter int          AW           = 16,
  parameter int          XW           = 9,
  parameter int          YW           = 9,
  parameter int          ACT_X0       = 48,
  parameter int          ACT_Y0       = 16,
  parameter int          STALL_LEAD   = 3,
  parameter logic [15:0] SCREEN_BASE  = 16'h0400,
  parameter logic [15:0] CHARSET_BASE = 16'h1000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [XW-1:0] rasterX,
  input  logic [YW-1:0] rasterY,
  output logic          memReq,
  output logic [AW-1:0] memAddr,
  input  logic [7:0]    memData,
  output logic          cpuStall,
  output logic          pixOut
);
  tvfStrobes_t strobes;

  tvf_ctrl #(
    .COLS(COLS), .ROWS(ROWS), .XW(XW), .YW(YW),
    .ACT_X0(ACT_X0), .ACT_Y0(ACT_Y0), .STALL_LEAD(STALL_LEAD)
  ) u_ctrl (
    .rasterX(rasterX),
    .rasterY(rasterY),
    .strobes(strobes)
  );

  tvf_datapath #(
    .COLS(COLS), .AW(AW), .SCREEN_BASE(SCREEN_BASE), .CHARSET_BASE(CHARSET_BASE)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .memData(memData),
    .memReq(memReq),
    .memAddr(memAddr),
    .cpuStall(cpuStall),
    .pixOut(pixOut)
  );
endmodule

// File: rtl/text_video_fetch_chk.sv
module text_video_fetch_chk
  import tvf_pkg::*;
#(
  parameter int          COLS        = 40,
  parameter int          ROWS        = 25,
  parameter int          AW          = 16,
  parameter int          YW          = 9,
  parameter int          ACT_Y0      = 16,
  parameter logic [15:0] SCREEN_BASE = 16'h0400
) (
  input logic          clk,
  input logic          rstN,
  input logic [YW-1:0] rasterY,
  input logic          memReq,
  input logic [AW-1:0] memAddr,
  input logic          cpuStall,
  input logic          pixOut,
  input tvfStrobes_t   strobes
);
  localparam logic [AW-1:0] SCR_LO = AW'(SCREEN_BASE);
  localparam logic [AW-1:0] SCR_HI = AW'(SCREEN_BASE) + AW'(COLS * ROWS);
  localparam logic [YW-1:0] Y_LO   = YW'(ACT_Y0);
  localparam logic [YW-1:0] Y_HI   = YW'(ACT_Y0 + 8 * ROWS);

  p_ptr_under_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ptrReq |-> cpuStall);

  p_ptr_addr_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ptrReq && memReq) |-> (memAddr >= SCR_LO && memAddr < SCR_HI));

  p_stall_first_line_r3: assert property (@(posedge clk) disable iff (!rstN)
    cpuStall |-> (strobes.lineInRow == 3'd0 && rasterY >= Y_LO && rasterY < Y_HI));

  p_one_kind_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.ptrReq, strobes.glyphReq}));

  p_glyph_line_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.glyphReq && memReq) |-> (memAddr[2:0] == strobes.lineInRow));

  p_capture_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.glyphCapture |-> $past(strobes.glyphReq));

  p_dark_outside_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.pixActive |=> !pixOut);
endmodule

bind text_video_fetch text_video_fetch_chk #(
  .COLS(COLS), .ROWS(ROWS), .AW(AW), .YW(YW), .ACT_Y0(ACT_Y0), .SCREEN_BASE(SCREEN_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .rasterY(rasterY), .memReq(memReq), .memAddr(memAddr),
  .cpuStall(cpuStall), .pixOut(pixOut), .strobes(strobes)
);

// File: tb/text_video_fetch_bench.sv
module text_video_fetch_bench;
  localparam int COLS = 40, ROWS = 25, ACT_X0 = 48, ACT_Y0 = 16, LINE_LEN = 400;
  localparam int SB = 16'h0400, CB = 16'h1000, FX0 = ACT_X0 - 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  rasterX = '0;
  logic [8:0]  rasterY = '0;
  logic        memReq;
  logic [15:0] memAddr;
  logic [7:0]  memData = '0;
  logic        cpuStall;
  logic        pixOut;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mem [8192];
  logic [7:0] expCode [COLS];

  always #10 clk = ~clk;

  text_video_fetch u_text_video_fetch (
    .clk(clk), .rstN(rstN), .rasterX(rasterX), .rasterY(rasterY),
    .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .cpuStall(cpuStall), .pixOut(pixOut)
  );

  // Synchronous memory, one-cycle read latency (R10)
  always @(posedge clk) if (memReq) memData <= mem[memAddr[12:0]];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s x=%0d y=%0d actual=%0h expected=%0h", req, rasterX, rasterY, act, exp);
    end
  endtask

  function automatic bit isActive(int y);
    return (y >= ACT_Y0) && (y < ACT_Y0 + 8 * ROWS);
  endfunction

  function automatic bit expStall(int x, int y);
    return isActive(y) && ((y - ACT_Y0) % 8 == 0) && (x >= FX0 - 3) && (x <= FX0 + 8 * (COLS - 1) + 5);
  endfunction

  // Expected request: returns 1 and the address if a read is due.
  function automatic bit expReq(int x, int y, output int addr);
    int ry, rel;
    addr = 0;
    if (!isActive(y) || x < FX0 || x >= FX0 + 8 * (COLS + 1)) return 0;
    ry = y - ACT_Y0; rel = x - FX0;
    if (ry % 8 == 0 && rel % 8 == 4 && rel / 8 < COLS) begin
      addr = SB + (ry / 8) * COLS + rel / 8;
      return 1;
    end
    if (rel % 8 == 0 && rel / 8 >= 1) begin
      addr = CB + int'(expCode[rel / 8 - 1]) * 8 + ry % 8;
      return 1;
    end
    return 0;
  endfunction

  function automatic bit expPix(int x, int y);
    int c, i, g;
    if (!isActive(y) || x < ACT_X0 || x >= ACT_X0 + 8 * COLS) return 1'b0;
    c = (x - ACT_X0) / 8; i = (x - ACT_X0) % 8;
    g = mem[CB + int'(expCode[c]) * 8 + (y - ACT_Y0) % 8];
    return g[7 - i];
  endfunction

  task automatic rewriteScreen();
    for (int k = 0; k < COLS * ROWS; k++) mem[SB + k] = 8'($urandom);
  endtask

  task automatic runLine(input int y);
    bit prevPix = 1'b0;
    int addr;
    bit req;
    if (isActive(y) && (y - ACT_Y0) % 8 == 0)
      for (int k = 0; k < COLS; k++) expCode[k] = mem[SB + ((y - ACT_Y0) / 8) * COLS + k];
    for (int x = 0; x < LINE_LEN; x++) begin
      @(negedge clk);
      if (x > 0) chk(pixOut == prevPix, (isActive(y) ? "R7/R8 pixel" : "R9 dark"), pixOut, prevPix);
      rasterX = 9'(x); rasterY = 9'(y);
      #1;
      req = expReq(x, y, addr);
      chk(memReq == req, (isActive(y) ? "R6/R2 request timing" : "R1 idle"), memReq, req);
      if (req && memReq)
        chk(memAddr == 16'(addr), ((y - ACT_Y0) % 8 == 0 && (x - FX0) % 8 == 4) ? "R2 code addr" : "R4/R5 glyph addr",
            memAddr, addr);
      chk(cpuStall == expStall(x, y), "R3 stall", cpuStall, expStall(x, y));
      prevPix = expPix(x, y);
    end
    @(negedge clk);
    chk(pixOut == prevPix, "R7 last pixel", pixOut, prevPix);
    rasterX = '0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seedDummy;
    int r;
    seedDummy = $urandom(32'd20240917);
    for (int k = 0; k < 8192; k++) mem[k] = 8'($urandom);
    for (int k = 0; k < COLS; k++) expCode[k] = 8'h00;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(pixOut == 1'b0, "R1 reset pix", pixOut, 0);
    chk(memReq == 1'b0, "R1 reset req", memReq, 0);
    chk(cpuStall == 1'b0, "R1 reset stall", cpuStall, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(pixOut == 1'b0, "R1 after reset", pixOut, 0);
    runLine(5);                                   // R1 outside band
    runLine(16);                                  // row 0 fetch line
    rewriteScreen();
    runLine(17); runLine(20); runLine(23);        // R5 reuse
    // R8: distinct first, second and last codes on row 1
    mem[SB + COLS + 0]        = 8'hFF;
    mem[SB + COLS + 1]        = 8'h02;
    mem[SB + COLS + COLS - 1] = 8'h01;
    mem[CB + 8'hFF * 8] = 8'hA5; mem[CB + 2 * 8] = 8'h3C; mem[CB + 1 * 8] = 8'h81;
    runLine(24);
    rewriteScreen();
    runLine(31);
    for (int n = 0; n < 4; n++) begin
      r = $urandom_range(2, 23);
      runLine(ACT_Y0 + 8 * r);
      rewriteScreen();
      runLine(ACT_Y0 + 8 * r + $urandom_range(1, 7));
    end
    runLine(ACT_Y0 + 8 * 24);                     // last row
    rewriteScreen();
    runLine(ACT_Y0 + 8 * 25 - 1);                 // last active line
    runLine(ACT_Y0 + 8 * 25);                     // R9/R1 first line below band
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule